// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block decides which interrupt a 16550-style UART reports to its host. It watches five event sources: a receiver line error, receive data at or above the trigger level, a receive character time-out, an empty transmit holding register, and a modem status change. Each source has its own enable bit. The enabled pending sources pass through a fixed-priority arbiter, and the winner goes into a registered 8-bit status byte. An active-high interrupt line is raised whenever that byte shows a pending source.

The block compares a receive FIFO fill count, supplied from outside, against a trigger level chosen by the FIFO control field. The line-error, data-ready and time-out sources are level conditions. The transmit-empty and modem sources are latched events. A host read of the status byte acknowledges only the source it reported, so any lower-priority source that is still pending shows up on the following read.

All outputs are registered. The status byte and the interrupt line reflect the inputs sampled at the previous rising clock edge.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, the status byte reads 0x01 and `irq_o` is low.
- R2: Priority, from highest to lowest, is: line error, then data ready, then time-out, then transmit empty, then modem status. The status bits [3:0] carry the winning source's code: line error 0110, data ready 0100, time-out 1100, transmit empty 0010, modem 0000, and none pending 0001.
- R3: Status bit 0 is 0 exactly when some enabled source is pending. `irq_o` is the inverse of that bit.
- R4: Status bits [7:6] are both 1 when `fifo_en_i` is high and both 0 when it is low. Bits [5:4] are always 0.
- R5: A read of the status byte clears only the latched source it reported. A lower-priority latched source that is still pending becomes the code seen after that read.
- R6: The line-error, data-ready and time-out sources stay reported across reads for as long as their cause holds.
- R7: With the FIFOs enabled, `trig_sel_i` sets the data-ready threshold: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. Data ready holds while `rx_cnt_i` is at or above the threshold.
- R8: With the FIFOs disabled, the threshold is 1 byte and the time-out source is suppressed.
- R9: The bits of `irq_en_i` gate the sources as follows. Bit 0 gates data ready and time-out, bit 1 gates transmit empty, bit 2 gates line error, and bit 3 gates modem status. A disabled source never appears in the code.
- R10: The transmit-empty source is set only on a rising edge of `thr_empty_i`. It is cleared by the read that reports it, or by `thr_wr_i`. A write in the same cycle as a rising edge leaves the source clear.
- R11: The modem source is set on a rising edge of `msr_chg_i` and cleared by the read that reports it. A rising edge in the same cycle as that read keeps the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_en_i | input | 4 | Per-source interrupt enables |
| fifo_en_i | input | 1 | FIFOs enabled |
| trig_sel_i | input | 2 | Receive trigger level select |
| rx_cnt_i | input | CNT_W | Receive FIFO fill count |
| line_err_i | input | 1 | Receiver line error condition |
| rx_tmo_i | input | 1 | Receive character time-out condition |
| thr_empty_i | input | 1 | Transmit holding register empty |
| thr_wr_i | input | 1 | Write strobe to the transmit holding register |
| msr_chg_i | input | 1 | Modem status change condition |
| rd_isr_i | input | 1 | Host read strobe for the status byte |
| isr_o | output | 8 | Interrupt status byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Two actions can land on the same latched source in a single cycle. A host read can acknowledge a source while a new rising event arrives for it, and a holding-register write can coincide with a new transmit-empty edge. Directed sequences raise `msr_chg_i` in the very cycle in which the read reports the modem code, and pulse `thr_wr_i` together with a rising `thr_empty_i`. The next status byte then has to show the modem source still pending and the transmit source clear. A long pseudo-random sweep also mixes reads, writes and edges freely, and an arithmetic model in the bench judges every cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    ID_LS   = 4'b0110,
    ID_RXD  = 4'b0100,
    ID_TMO  = 4'b1100,
    ID_THR  = 4'b0010,
    ID_MS   = 4'b0000,
    ID_NONE = 4'b0001
  } irq_id_e;

  // source index == priority rank, 0 highest
  localparam int unsigned NSRC    = 5;
  localparam int unsigned SRC_LS  = 0;
  localparam int unsigned SRC_RXD = 1;
  localparam int unsigned SRC_TMO = 2;
  localparam int unsigned SRC_THR = 3;
  localparam int unsigned SRC_MS  = 4;

  // enable bit positions
  localparam int unsigned IEN_RX = 0;
  localparam int unsigned IEN_TX = 1;
  localparam int unsigned IEN_LS = 2;
  localparam int unsigned IEN_MS = 3;

  function automatic irq_id_e id_of(input int unsigned idx);
    case (idx)
      SRC_LS:  return ID_LS;
      SRC_RXD: return ID_RXD;
      SRC_TMO: return ID_TMO;
      SRC_THR: return ID_THR;
      default: return ID_MS;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             fifo_en_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] lvl;

  always_comb begin
    if (!fifo_en_i) lvl = CNT_W'(1);
    else begin
      case (sel_i)
        2'd0:    lvl = CNT_W'(1);
        2'd1:    lvl = CNT_W'(4);
        2'd2:    lvl = CNT_W'(8);
        default: lvl = CNT_W'(14);
      endcase
    end
  end

  assign hit_o = (cnt_i >= lvl);
endmodule

// File: rtl/uart_irq_evt.sv
module uart_irq_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic pend_o,
  output logic pend_nxt_o
);
  logic prev_q, pend_q, rise;

  assign rise = cond_i & ~prev_q;

  // write clear beats a new edge; a new edge beats the read ack
  always_comb begin
    if (clr_i)      pend_nxt_o = 1'b0;
    else if (rise)  pend_nxt_o = 1'b1;
    else if (ack_i) pend_nxt_o = 1'b0;
    else            pend_nxt_o = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= cond_i;
      pend_q <= pend_nxt_o;
    end
  end

  assign pend_o = pend_q;

  assert_rise_sets_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i && !prev_q && !clr_i) |=> pend_q);
  assert_wr_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_q);
  assert_no_spurious_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !(cond_i && !prev_q)) |=> !pend_q);
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] pend_i,
  input  logic            fifo_en_i,
  output logic [7:0]      isr_o,
  output logic            irq_o
);
  irq_id_e code_d;
  logic [3:0] code_q;
  logic fifo_q;

  always_comb begin
    code_d = ID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i]) code_d = id_of(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= ID_NONE;
      fifo_q <= 1'b0;
    end else begin
      code_q <= code_d;
      fifo_q <= fifo_en_i;
    end
  end

  assign isr_o = {fifo_q, fifo_q, 2'b00, code_q};
  assign irq_o = ~code_q[0];

  assert_top_prio_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i[SRC_LS] |=> (isr_o[3:0] == ID_LS));
  assert_rxd_over_tmo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[SRC_RXD] && !pend_i[SRC_LS]) |=> (isr_o[3:0] == ID_RXD));
  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |=> (isr_o[0] && !irq_o));
  assert_fifo_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i |=> (isr_o[7:4] == 4'b1100));
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       irq_en_i,
  input  logic             fifo_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             line_err_i,
  input  logic             rx_tmo_i,
  input  logic             thr_empty_i,
  input  logic             thr_wr_i,
  input  logic             msr_chg_i,
  input  logic             rd_isr_i,
  output logic [7:0]       isr_o,
  output logic             irq_o
);
  localparam int unsigned NEVT = 2; // 0: transmit empty, 1: modem

  logic            trig_hit;
  logic [NEVT-1:0] ev_cond, ev_clr, ev_ack, ev_pend, ev_nxt;
  logic [NSRC-1:0] pend;

  uart_irq_trig #(.CNT_W(CNT_W)) u_trig (
    .fifo_en_i (fifo_en_i),
    .sel_i     (trig_sel_i),
    .cnt_i     (rx_cnt_i),
    .hit_o     (trig_hit)
  );

  assign ev_cond = {msr_chg_i, thr_empty_i};
  assign ev_clr  = {1'b0, thr_wr_i};
  assign ev_ack  = {rd_isr_i && (isr_o[3:0] == ID_MS),
                    rd_isr_i && (isr_o[3:0] == ID_THR)};

  for (genvar g = 0; g < NEVT; g++) begin : g_evt
    uart_irq_evt u_evt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cond_i     (ev_cond[g]),
      .clr_i      (ev_clr[g]),
      .ack_i      (ev_ack[g]),
      .pend_o     (ev_pend[g]),
      .pend_nxt_o (ev_nxt[g])
    );
  end

  // latched sources use their post-acknowledge value so a read lands in one cycle
  assign pend[SRC_LS]  = line_err_i & irq_en_i[IEN_LS];
  assign pend[SRC_RXD] = trig_hit & irq_en_i[IEN_RX];
  assign pend[SRC_TMO] = rx_tmo_i & fifo_en_i & irq_en_i[IEN_RX];
  assign pend[SRC_THR] = ev_nxt[0] & irq_en_i[IEN_TX];
  assign pend[SRC_MS]  = ev_nxt[1] & irq_en_i[IEN_MS];

  uart_irq_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend),
    .fifo_en_i (fifo_en_i),
    .isr_o     (isr_o),
    .irq_o     (irq_o)
  );

  assert_ms_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i[IEN_MS] |=> (isr_o[3:0] != ID_MS));
  assert_tmo_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !line_err_i && rx_cnt_i == '0) |=> (isr_o[3:0] != ID_TMO && isr_o[3:0] != ID_RXD));
  assert_ack_moves_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_isr_i && isr_o[3:0] == ID_MS && !(msr_chg_i && !ev_pend[1] && !$past(msr_chg_i)) && !msr_chg_i)
      |=> (isr_o[3:0] != ID_MS));
  assert_irq_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend != '0) |=> irq_o);
endmodule

// File: tb/tb_uart_irq_id.sv
module tb_uart_irq_id;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] en = '0;
  logic fe = 1'b0;
  logic [1:0] sel = '0;
  logic [CNT_W-1:0] cnt = '0;
  logic lerr = 1'b0, tmo = 1'b0, thre = 1'b0, twr = 1'b0, msr = 1'b0, rd = 1'b0;
  logic [7:0] isr;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic m_thr = 0, m_ms = 0, m_thr_prev = 0, m_ms_prev = 0;
  logic [3:0] m_code = 4'b0001;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  uart_irq_id #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_en_i(en), .fifo_en_i(fe), .trig_sel_i(sel),
    .rx_cnt_i(cnt), .line_err_i(lerr), .rx_tmo_i(tmo), .thr_empty_i(thre),
    .thr_wr_i(twr), .msr_chg_i(msr), .rd_isr_i(rd), .isr_o(isr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one clock: model from requirements, then compare after the edge
  task automatic step(input string req);
    int lvl;
    logic thr_n, ms_n, rxd, ls, to, t, m;
    logic [3:0] c;
    lvl = !fe ? 1 : (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
    if (twr) thr_n = 0;
    else if (thre && !m_thr_prev) thr_n = 1;
    else if (rd && m_code == 4'b0010) thr_n = 0;
    else thr_n = m_thr;
    if (msr && !m_ms_prev) ms_n = 1;
    else if (rd && m_code == 4'b0000) ms_n = 0;
    else ms_n = m_ms;
    ls  = lerr & en[2];
    rxd = (int'(cnt) >= lvl) & en[0];
    to  = tmo & fe & en[0];
    t   = thr_n & en[1];
    m   = ms_n & en[3];
    c = ls ? 4'b0110 : rxd ? 4'b0100 : to ? 4'b1100 : t ? 4'b0010 : m ? 4'b0000 : 4'b0001;
    m_thr = thr_n; m_ms = ms_n; m_thr_prev = thre; m_ms_prev = msr; m_code = c;
    @(posedge clk); #1;
    chk(req, isr, {fe, fe, 2'b00, c});
    chk("R3", {7'd0, irq}, {7'd0, ~c[0]});
  endtask

  task automatic idle();
    en = '0; fe = 0; sel = 0; cnt = '0; lerr = 0; tmo = 0; thre = 0; twr = 0; msr = 0; rd = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #5;
    chk("R1", isr, 8'h01);
    chk("R1", {7'd0, irq}, 8'h00);
    @(posedge clk); #1; rst_n = 1;
    chk("R1", isr, 8'h01);

    // R7 R8: trigger sweep, data-ready only
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 4; s++)
        for (int k = 0; k < 17; k++) begin
          idle(); en = 4'b0001; fe = f[0]; sel = s[1:0]; cnt = CNT_W'(k);
          step("R7 R8");
        end

    // R8: time-out suppressed with FIFOs off, present with FIFOs on
    idle(); en = 4'b0001; tmo = 1; step("R8");
    fe = 1; step("R8");

    // R5: transmit then modem, each read acks only the reported source
    idle(); en = 4'b1010; thre = 1; msr = 1; step("R5");
    msr = 0; rd = 1; step("R5");
    step("R5");
    rd = 0; step("R5");

    // R6: level source survives reads
    idle(); en = 4'b0100; lerr = 1; rd = 1;
    for (int i = 0; i < 4; i++) step("R6");
    lerr = 0; step("R6");

    // R10: edge only, read clears while empty still held, write beats edge
    idle(); en = 4'b0010; step("R10");
    thre = 1; step("R10");
    step("R10");
    rd = 1; step("R10");
    rd = 0; step("R10");
    thre = 0; step("R10");
    thre = 1; twr = 1; step("R10");
    twr = 0; thre = 0; step("R10");
    thre = 1; step("R10");
    thre = 0; twr = 1; step("R10");
    twr = 0; step("R10");

    // R11: new edge in the read cycle keeps modem pending
    idle(); en = 4'b1000; msr = 1; step("R11");
    msr = 0; step("R11");
    msr = 1; rd = 1; step("R11");
    msr = 0; step("R11");
    rd = 0; step("R11");

    // R9: everything active, nothing enabled
    idle(); fe = 1; lerr = 1; tmo = 1; cnt = CNT_W'(16); thre = 1; msr = 1;
    step("R9"); step("R9");
    en = 4'b1000; msr = 0; step("R9");
    msr = 1; step("R9");

    // R2 R4: pseudo-random sweep
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lerr = (lfsr[2:0] == 3'd0);
      tmo  = lfsr[3];
      thre = lfsr[4];
      twr  = (lfsr[7:5] == 3'd0);
      msr  = lfsr[8];
      rd   = lfsr[9];
      en   = lfsr[13:10];
      fe   = lfsr[14];
      sel  = lfsr[1:0] ^ lfsr[15:14];
      cnt  = CNT_W'(int'(lfsr[15:8]) % 17);
      step("R2 R4");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule